// File: doc/BRIEF.md
# Field Event Interrupt Controller

This block collects the field events of a video timing generator and turns them into one interrupt request. A pulse on the bottom-field event input or the top-field event input sets a sticky bit in a 16-bit status register. Software clears status bits by writing ones to a clear-only alias of that register. The interrupt mask is a second 16-bit register. It is changed only through a set alias and a clear alias, so software never has to do a read-modify-write.

The interrupt line is a level signal. It is high while any status bit and the mask bit in the same position are both set. A small two-state machine drives it. In state `IRQ_QUIET` the line is low. The transition *raise* (some unmasked status bit is pending) moves the machine to `IRQ_RAISED`, where the line is high. The transition *drop* (no unmasked bit is pending) moves it back to `IRQ_QUIET`. Both states hold while their entry condition persists. Because the machine is registered, the line follows the pending condition one clock later.

A typical enable sequence writes 0xFFFF to the status clear alias, then 0xFFFF to the mask clear alias, and then sets mask bits 0 and 1 through the set alias. The register port has an address, a write strobe, write data, and combinational read data. The register addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | status | read |
| 1 | status clear alias | write |
| 2 | mask | read |
| 3 | mask clear alias | write |
| 4 | mask set alias | write |

Top module: `fei_ctrl`

## Requirements
- R1: After reset, the status register (address 0) reads 0 and the mask register (address 2) reads 0, and `irq` is low.
- R2: A one-cycle pulse on `evt_bot` sets status bit 0, and a pulse on `evt_top` sets status bit 1. The bit is visible at address 0 after the clock edge that samples the pulse.
- R3: Writing a value to address 1 clears exactly the status bits that are 1 in the written value. Writing 0xFFFF clears every status bit.
- R4: If an event and a clear of the same status bit occur in the same cycle, the bit stays set.
- R5: Writing a value to address 4 sets exactly the mask bits that are 1 in the written value. All other mask bits keep their values.
- R6: Writing a value to address 3 clears exactly the mask bits that are 1 in the written value. Writing 0xFFFF clears all 16 mask bits.
- R7: Status bits latch events even while masked, and `irq` stays low. Setting the mask bit afterwards raises `irq` without any new event.
- R8: `irq` goes high on the clock edge after the one at which some status bit and its mask bit are both 1. It stays high while that holds, and goes low on the clock edge after no such pair remains.
- R9: Reads of the write-only aliases (addresses 1, 3, 4) and of unmapped addresses (5 to 7) return 0.
- R10: Writes to address 0 and address 2 have no effect on the status register, the mask register or `irq`.
- R11: Status bits 15 to 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_bot | input | 1 | Bottom-field event pulse (status bit 0) |
| evt_top | input | 1 | Top-field event pulse (status bit 1) |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is an event and a clear of the same bit in one clock cycle. It needs the event pulse and the clear-alias write to be driven on the same falling edge. The stimulus does exactly that, and then reads the status to confirm the event won. A second case that is hard to reach is a masked pending bit that is later unmasked. The bench raises an event with the mask at zero, confirms that `irq` stays low over several cycles, and then sets the mask bit. It checks that `irq` is still low in the cycle the mask changes and high one cycle later.

// File: rtl/fei_pkg.sv
package fei_pkg;

    // Register addresses (3-bit address space)
    localparam int A_STAT     = 0;
    localparam int A_STAT_CLR = 1;
    localparam int A_MASK     = 2;
    localparam int A_MASK_CLR = 3;
    localparam int A_MASK_SET = 4;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_STAT_CLR,
        WR_MASK_CLR,
        WR_MASK_SET,
        WR_IGNORED
    } wr_kind_e;

endpackage

// File: rtl/fei_status_reg.sv
module fei_status_reg #(
    parameter int W     = 16,
    parameter int N_EVT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic [W-1:0]     clr_bits,
    output logic [W-1:0]     status_q
);

    logic [W-1:0] evt_ext;

    // Widen the event vector to the register width; unused bits stay zero
    for (genvar g = 0; g < W; g++) begin : g_evt
        if (g < N_EVT) begin : g_src
            assign evt_ext[g] = evt[g];
        end else begin : g_none
            assign evt_ext[g] = 1'b0;
        end
    end

    // Clear first, then OR in events, so an event beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | evt_ext;
        end
    end

    // R2: an event sets its status bit at the next edge
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status_q[N_EVT-1:0] & $past(evt)) == $past(evt)));

    // R3: cleared bits (without a competing event) read zero afterwards
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((status_q & $past(clr_bits & ~evt_ext)) == '0));

    // R4: an event colliding with a clear leaves the bit set
    p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & clr_bits[N_EVT-1:0])) |=>
        ((status_q[N_EVT-1:0] & $past(evt & clr_bits[N_EVT-1:0])) ==
         $past(evt & clr_bits[N_EVT-1:0])));

endmodule

// File: rtl/fei_mask_reg.sv
module fei_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | set_bits) & ~clr_bits;
        end
    end

    // R5: set alias turns on the written-one bits and leaves the others alone
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_bits) && (clr_bits == '0)) |=>
        (mask_q == ($past(mask_q) | $past(set_bits))));

    // R6: clear alias turns off the written-one bits and leaves the others alone
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|clr_bits) && (set_bits == '0)) |=>
        (mask_q == ($past(mask_q) & ~$past(clr_bits))));

endmodule

// File: rtl/fei_irq_fsm.sv
module fei_irq_fsm
    import fei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        irq     = 1'b0;
        unique case (state_q)
            IRQ_QUIET: begin
                irq = 1'b0;
                if (pend) state_d = IRQ_RAISED;   // raise
            end
            IRQ_RAISED: begin
                irq = 1'b1;
                if (!pend) state_d = IRQ_QUIET;   // drop
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    // R8: irq follows the pending condition one cycle later
    p_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> irq);
    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !irq);

endmodule

// File: rtl/fei_ctrl.sv
module fei_ctrl
    import fei_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_bot,
    input  logic              evt_top,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int N_EVT = 2;

    wr_kind_e          wr_kind;
    logic [DATA_W-1:0] stat_clr;
    logic [DATA_W-1:0] mask_set;
    logic [DATA_W-1:0] mask_clr;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;
    logic [N_EVT-1:0]  evt;
    logic              pend;

    assign evt = {evt_top, evt_bot};   // bit 0 bottom, bit 1 top

    // Write decode
    always_comb begin
        wr_kind = WR_NONE;
        if (we) begin
            case (addr)
                ADDR_W'(A_STAT_CLR): wr_kind = WR_STAT_CLR;
                ADDR_W'(A_MASK_CLR): wr_kind = WR_MASK_CLR;
                ADDR_W'(A_MASK_SET): wr_kind = WR_MASK_SET;
                default:             wr_kind = WR_IGNORED;
            endcase
        end
    end

    assign stat_clr = (wr_kind == WR_STAT_CLR) ? wdata : '0;
    assign mask_clr = (wr_kind == WR_MASK_CLR) ? wdata : '0;
    assign mask_set = (wr_kind == WR_MASK_SET) ? wdata : '0;

    fei_status_reg #(.W(DATA_W), .N_EVT(N_EVT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_bits (stat_clr),
        .status_q (status_q)
    );

    fei_mask_reg #(.W(DATA_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (mask_set),
        .clr_bits (mask_clr),
        .mask_q   (mask_q)
    );

    assign pend = |(status_q & mask_q);

    fei_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .irq   (irq)
    );

    // Read mux: aliases and holes read zero
    always_comb begin
        case (addr)
            ADDR_W'(A_STAT): rdata = status_q;
            ADDR_W'(A_MASK): rdata = mask_q;
            default:         rdata = '0;
        endcase
    end

    // R10: a write to the mask read address leaves the mask unchanged
    p_mask_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(A_MASK)) |=> $stable(mask_q));

    // R10: a write to the status read address with no event leaves status unchanged
    p_stat_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(A_STAT) && evt == '0) |=> $stable(status_q));

    // R11: bits with no event source never become set
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[DATA_W-1:N_EVT] == '0);

endmodule

// File: tb/tb_fei_ctrl.sv
`timescale 1ns/1ps
module tb_fei_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_bot = 1'b0;
    logic        evt_top = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fei_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_bot(evt_bot), .evt_top(evt_top),
        .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Read a register combinationally, between clock edges
    task automatic rd(input logic [2:0] a, input string req, input logic [15:0] exp);
        addr = a;
        #0.5;
        check(req, rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        #0.5;
        check(req, {15'd0, irq}, {15'd0, exp});
    endtask

    // Write: drive at a falling edge, captured at the next rising edge;
    // returns on the following falling edge with registers updated
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic pulse(input logic bot, input logic top);
        @(negedge clk);
        evt_bot = bot; evt_top = top;
        @(negedge clk);
        evt_bot = 1'b0; evt_top = 1'b0;
    endtask

    task automatic t_reset;
        rd(3'd0, "R1 status", 16'h0000);
        rd(3'd2, "R1 mask", 16'h0000);
        chk_irq("R1 irq", 1'b0);
    endtask

    task automatic t_events;
        pulse(1'b1, 1'b0);
        rd(3'd0, "R2 bottom sets bit0", 16'h0001);
        pulse(1'b0, 1'b1);
        rd(3'd0, "R2 top sets bit1", 16'h0003);
        chk_irq("R7 masked no irq", 1'b0);
        rd(3'd0, "R11 upper bits zero", 16'h0003);
        wr(3'd1, 16'h0001);
        rd(3'd0, "R3 clear bit0 only", 16'h0002);
        wr(3'd1, 16'hFFFF);
        rd(3'd0, "R3 clear all", 16'h0000);
    endtask

    task automatic t_mask;
        wr(3'd4, 16'h0005);
        rd(3'd2, "R5 set 0x0005", 16'h0005);
        wr(3'd4, 16'h0002);
        rd(3'd2, "R5 set keeps others", 16'h0007);
        wr(3'd3, 16'h0004);
        rd(3'd2, "R6 clear bit2 only", 16'h0003);
        wr(3'd4, 16'hFFFF);
        rd(3'd2, "R5 set all", 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        rd(3'd2, "R6 clear all", 16'h0000);
    endtask

    task automatic t_masked_pending;
        pulse(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk_irq("R7 masked pending keeps irq low", 1'b0);
        rd(3'd0, "R7 status latched while masked", 16'h0001);
        wr(3'd4, 16'h0001);
        chk_irq("R8 irq not yet at mask edge", 1'b0);
        @(negedge clk);
        chk_irq("R7 unmask raises irq", 1'b1);
    endtask

    task automatic t_irq_level;
        repeat (4) @(negedge clk);
        chk_irq("R8 irq holds level", 1'b1);
        wr(3'd1, 16'h0001);
        chk_irq("R8 irq still high one cycle", 1'b1);
        @(negedge clk);
        chk_irq("R8 irq drops after clear", 1'b0);
    endtask

    task automatic t_collision;
        @(negedge clk);
        evt_top = 1'b1; we = 1'b1; addr = 3'd1; wdata = 16'h0002;
        @(negedge clk);
        evt_top = 1'b0; we = 1'b0;
        rd(3'd0, "R4 event wins over clear", 16'h0002);
        wr(3'd1, 16'h0002);
        rd(3'd0, "R3 clear after collision", 16'h0000);
    endtask

    task automatic t_alias_reads;
        pulse(1'b1, 1'b1);
        wr(3'd4, 16'h00F3);
        for (int a = 1; a < 8; a++) begin
            if (a != 2) rd(3'(a), $sformatf("R9 read addr %0d", a), 16'h0000);
        end
    endtask

    task automatic t_ro_writes;
        @(negedge clk);
        chk_irq("R10 irq before", 1'b1);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, "R10 status unchanged", 16'h0003);
        wr(3'd2, 16'h0000);
        rd(3'd2, "R10 mask unchanged", 16'h00F3);
        @(negedge clk);
        chk_irq("R10 irq unchanged", 1'b1);
    endtask

    task automatic t_enable_seq;
        wr(3'd1, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd4, 16'h0003);
        rd(3'd0, "R3 enable seq status", 16'h0000);
        rd(3'd2, "R6 enable seq mask", 16'h0003);
        @(negedge clk);
        chk_irq("R8 irq low after enable", 1'b0);
        pulse(1'b0, 1'b1);
        chk_irq("R8 irq low same cycle as status", 1'b0);
        @(negedge clk);
        chk_irq("R8 top event raises irq", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_mask();
        t_masked_pending();
        t_irq_level();
        t_collision();
        t_alias_reads();
        t_ro_writes();
        t_enable_seq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule